// File: doc/BRIEF.md
# Iterative AES-128 Encryption Core

This core turns one 128-bit plaintext block into its AES-128 ciphertext under a 128-bit cipher key. A single combinational round unit is shared by all ten rounds. Each round key is derived from the previous one in the same cycle that the round uses it, so the core holds only the current round key and never a schedule memory.

A caller presents key and plaintext and raises `start_i` for one cycle while the core is idle. The core then spends one cycle on the initial key addition and one cycle on each of the ten rounds. It pulses `done_o` for one cycle with the ciphertext on `ct_o`. The ciphertext stays there until the next accepted start.

The controller has two named states. IDLE waits for a start. ROUND executes one round per cycle. The transitions are:

- IDLE -> ROUND on an accepted start. This cycle loads plaintext XOR key.
- ROUND -> ROUND while the round index is below ten.
- ROUND -> IDLE on the tenth round. This transition raises `done_o` for the following cycle.

Top module: `aes128_iter_enc`

## Requirements
- R1: While reset is held and after it is released, `busy_o` and `done_o` are 0 and `ct_o` is all zeros.
- R2: `done_o` is high exactly 11 cycles after the cycle in which an accepted `start_i` is high. Those 11 cycles are one for the initial key addition and ten rounds.
- R3: `ct_o` at `done_o` equals AES-128 encryption, where rounds 1 to 9 apply substitution, row rotation, column mixing and key addition, and round 10 omits the column mixing. Key 000102..0f with plaintext 00112233..ff gives 69c4e0d86a7b0430d8cdb78070b4c55a. Key 2b7e151628aed2a6abf7158809cf4f3c with plaintext 3243f6a8885a308d313198a2e0370734 gives 3925841d02dc09fbdc118597196a0b32. An all-zero key with an all-zero plaintext gives 66e94bd4ef8a2c3b884cfa59ca342b2e.
- R4: Byte 0 of every 128-bit port is bits [127:120] and byte 15 is bits [7:0]. Byte i sits in row i mod 4 and column i div 4 of the state. Row r rotates left by r byte positions.
- R5: A `start_i` while `busy_o` is high is ignored. The running block finishes with its own result and timing, and no additional `done_o` follows.
- R6: `busy_o` is high from the cycle after an accepted start through the cycle before `done_o`. `done_o` lasts one cycle and is never high together with `busy_o`.
- R7: While the core is idle and `start_i` is low, `ct_o` does not change.
- R8: A `start_i` in the same cycle as `done_o` is accepted, giving back-to-back blocks.
- R9: Round keys are produced on the fly with round constants 01, 02, 04, 08, 10, 20, 40, 80, 1b, 36 for rounds 1 to 10. Each constant is XORed into the top byte of the rotated and substituted last word. Round 10 uses 36.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, honoured only when idle |
| key_i | input | 128 | Cipher key, byte 0 in bits [127:120] |
| pt_i | input | 128 | Plaintext block, byte 0 in bits [127:120] |
| busy_o | output | 1 | High while rounds are executing |
| done_o | output | 1 | One-cycle pulse when the ciphertext is ready |
| ct_o | output | 128 | Ciphertext, held until the next accepted start |

## Verification
The hardest situations to reach from the ports are a start request landing mid-flight and a start landing in the very cycle a block completes. The first must leave the running block untouched. The second must be accepted. The stimulus pulses a start with a different key and plaintext a few cycles into a block, then confirms that only the original ciphertext appears, on time, with no extra completion. A driver that waits only for `busy_o` to fall issues the next block in the completion cycle itself, so the back-to-back case arises naturally and is timed by the scoreboard.

// File: rtl/aes_core_pkg.sv
package aes_core_pkg;

    localparam int BLK_W      = 128;
    localparam int NUM_BYTES  = BLK_W / 8;
    localparam int NUM_ROUNDS = 10;
    localparam int CNT_W      = $clog2(NUM_ROUNDS + 2);

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ROUND = 1'b1
    } ctrl_state_t;

    // Multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

    // Multiplicative inverse as a^254 = a^2 * a^4 * ... * a^128 (0 maps to 0)
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] pw;
        logic [7:0] acc;
        pw  = gf_mul(a, a);
        acc = pw;
        for (int i = 0; i < 6; i++) begin
            pw  = gf_mul(pw, pw);
            acc = gf_mul(acc, pw);
        end
        return acc;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    function automatic logic [7:0] sbox_byte(input logic [7:0] a);
        logic [7:0] b;
        b = gf_inv(a);
        return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
    endfunction

endpackage

// File: rtl/aes_key_step.sv
module aes_key_step
    import aes_core_pkg::*;
(
    input  logic [BLK_W-1:0] key_i,
    input  logic [7:0]       rcon_i,
    output logic [BLK_W-1:0] key_o
);
    localparam int WORD_W = 32;

    logic [WORD_W-1:0] rot_w;
    logic [WORD_W-1:0] sub_w;
    logic [WORD_W-1:0] tmp_w;
    logic [WORD_W-1:0] nw0, nw1, nw2, nw3;

    // Rotate the last word left by one byte
    assign rot_w = {key_i[23:0], key_i[31:24]};

    for (genvar b = 0; b < 4; b++) begin : g_sub
        assign sub_w[8*b +: 8] = sbox_byte(rot_w[8*b +: 8]);
    end

    assign tmp_w = sub_w ^ {rcon_i, 24'h000000};
    assign nw0   = key_i[127:96] ^ tmp_w;
    assign nw1   = key_i[95:64]  ^ nw0;
    assign nw2   = key_i[63:32]  ^ nw1;
    assign nw3   = key_i[31:0]   ^ nw2;
    assign key_o = {nw0, nw1, nw2, nw3};

endmodule

// File: rtl/aes_round_unit.sv
module aes_round_unit
    import aes_core_pkg::*;
(
    input  logic [BLK_W-1:0] state_i,
    input  logic [BLK_W-1:0] rkey_i,
    input  logic             last_i,
    output logic [BLK_W-1:0] state_o
);
    logic [7:0] in_b  [NUM_BYTES];
    logic [7:0] sub_b [NUM_BYTES];
    logic [7:0] shf_b [NUM_BYTES];
    logic [7:0] mix_b [NUM_BYTES];

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_sub
        assign in_b[i]  = state_i[BLK_W-1-8*i -: 8];
        assign sub_b[i] = sbox_byte(in_b[i]);
    end

    // Row r of column c takes the byte from column (c + r) mod 4
    for (genvar c = 0; c < 4; c++) begin : g_col
        for (genvar r = 0; r < 4; r++) begin : g_row
            assign shf_b[4*c + r] = sub_b[4*((c + r) % 4) + r];
        end
    end

    for (genvar c = 0; c < 4; c++) begin : g_mix
        logic [7:0] a0, a1, a2, a3;
        assign a0 = shf_b[4*c];
        assign a1 = shf_b[4*c + 1];
        assign a2 = shf_b[4*c + 2];
        assign a3 = shf_b[4*c + 3];
        assign mix_b[4*c]     = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
        assign mix_b[4*c + 1] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
        assign mix_b[4*c + 2] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
        assign mix_b[4*c + 3] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
    end

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_ark
        assign state_o[BLK_W-1-8*i -: 8] =
            (last_i ? shf_b[i] : mix_b[i]) ^ rkey_i[BLK_W-1-8*i -: 8];
    end

endmodule

// File: rtl/aes_ctrl_fsm.sv
module aes_ctrl_fsm
    import aes_core_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic last_o,
    output logic busy_o,
    output logic done_o
);
    ctrl_state_t st_q, st_d;
    logic [CNT_W-1:0] rnd_q;
    logic [CNT_W-1:0] lat_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state and decoded controls
    always_comb begin
        st_d   = st_q;
        load_o = 1'b0;
        step_o = 1'b0;
        last_o = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                load_o = start_i;
                if (start_i) st_d = ST_ROUND;
            end
            ST_ROUND: begin
                step_o = 1'b1;
                last_o = (rnd_q == CNT_W'(NUM_ROUNDS));
                if (last_o) st_d = ST_IDLE;
            end
        endcase
    end

    assign busy_o = (st_q == ST_ROUND);

    // Registered outputs and round index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rnd_q  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= last_o;
            if (load_o)      rnd_q <= CNT_W'(1);
            else if (step_o) rnd_q <= rnd_q + CNT_W'(1);
        end
    end

    // Independent latency counter for the checks below
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lat_q <= '0;
        else if (load_o)  lat_q <= CNT_W'(1);
        else if (busy_o)  lat_q <= lat_q + CNT_W'(1);
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat_q == CNT_W'(NUM_ROUNDS + 1)));

    assert_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !last_o) |=> (busy_o && rnd_q == $past(rnd_q) + CNT_W'(1)));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

endmodule

// File: rtl/aes128_iter_enc.sv
module aes128_iter_enc
    import aes_core_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [BLK_W-1:0] key_i,
    input  logic [BLK_W-1:0] pt_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [BLK_W-1:0] ct_o
);
    logic             load, step, last;
    logic [BLK_W-1:0] state_q, key_q;
    logic [7:0]       rcon_q;
    logic [BLK_W-1:0] key_nxt, round_out;

    aes_ctrl_fsm u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .last_o  (last),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    aes_key_step u_key (
        .key_i  (key_q),
        .rcon_i (rcon_q),
        .key_o  (key_nxt)
    );

    aes_round_unit u_round (
        .state_i (state_q),
        .rkey_i  (key_nxt),
        .last_i  (last),
        .state_o (round_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
            key_q   <= '0;
            rcon_q  <= 8'h01;
        end else if (load) begin
            state_q <= pt_i ^ key_i;
            key_q   <= key_i;
            rcon_q  <= 8'h01;
        end else if (step) begin
            state_q <= round_out;
            key_q   <= key_nxt;
            rcon_q  <= xtime(rcon_q);
        end
    end

    assign ct_o = state_q;

    assert_ct_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(ct_o));

    assert_final_rcon_R9: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> (rcon_q == 8'h36));

    assert_first_rcon_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (rcon_q == 8'h01));

endmodule

// File: tb/aes128_iter_enc_tb_top.sv
module aes128_iter_enc_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [127:0] key_i = '0;
    logic [127:0] pt_i = '0;
    logic         busy_o, done_o;
    logic [127:0] ct_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int n_done = 0;
    int n_issued = 0;
    logic prev_done = 1'b0;

    logic [127:0] exp_q[$];
    int           cyc_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    aes128_iter_enc dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
        .pt_i(pt_i), .busy_o(busy_o), .done_o(done_o), .ct_o(ct_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Driver: waits for an idle core, issues one block, pushes the expectation
    task automatic issue(input logic [127:0] k, input logic [127:0] p, input logic [127:0] e);
        while (busy_o) @(negedge clk);
        key_i = k; pt_i = p; start_i = 1'b1;
        exp_q.push_back(e);
        cyc_q.push_back(cyc);
        n_issued++;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R6", "busy after start", 128'(busy_o), 128'd1);
    endtask

    // Monitor: compares each completion against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                n_done++;
                check(!prev_done, "R6", "done wider than one cycle", 128'(prev_done), 128'd0);
                check(busy_o === 1'b0, "R6", "busy during done", 128'(busy_o), 128'd0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "done without pending block", ct_o, '0);
                end else begin
                    logic [127:0] e;
                    int c0;
                    e  = exp_q.pop_front();
                    c0 = cyc_q.pop_front();
                    check(ct_o === e, "R3", "ciphertext", ct_o, e);
                    check((cyc - c0) == 11, "R2", "start-to-done cycles", 128'(cyc - c0), 128'd11);
                end
            end
            prev_done = done_o;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run did not finish", '0, '0);
        summary();
        $finish;
    end

    localparam logic [127:0] K1 = 128'h000102030405060708090a0b0c0d0e0f;
    localparam logic [127:0] P1 = 128'h00112233445566778899aabbccddeeff;
    localparam logic [127:0] E1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    localparam logic [127:0] K2 = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [127:0] P2 = 128'h3243f6a8885a308d313198a2e0370734;
    localparam logic [127:0] E2 = 128'h3925841d02dc09fbdc118597196a0b32;
    localparam logic [127:0] E3 = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;

    initial begin
        logic [127:0] held;
        repeat (3) @(negedge clk);
        // R1: reset values while held and after release
        check(busy_o === 1'b0, "R1", "busy in reset", 128'(busy_o), 128'd0);
        check(done_o === 1'b0, "R1", "done in reset", 128'(done_o), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(ct_o === '0, "R1", "ciphertext after reset", ct_o, '0);
        check(busy_o === 1'b0, "R1", "busy after reset", 128'(busy_o), 128'd0);

        // R3, R4, R9: known-answer block
        issue(K1, P1, E1);
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);

        // R8: back-to-back blocks, second issued in the done cycle
        issue(K2, P2, E2);
        issue('0, '0, E3);
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);

        // R5: start mid-flight with different inputs is ignored
        issue(K2, P2, E2);
        repeat (3) @(negedge clk);
        key_i = K1; pt_i = P1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);

        // R7: ciphertext held while idle
        held = ct_o;
        key_i = ~key_i; pt_i = ~pt_i;
        repeat (5) @(negedge clk);
        check(ct_o === held, "R7", "ciphertext held while idle", ct_o, held);
        check(ct_o === E2, "R5", "result unaffected by ignored start", ct_o, E2);
        check(n_done == n_issued, "R5", "completion count", 128'(n_done), 128'(n_issued));

        summary();
        $finish;
    end

endmodule